// File: doc/BRIEF.md
# Multi-mode interval timer channel

A single 16-bit down-counting timer channel driven by one clock, with a GATE input and an OUT output. A host writes a 3-bit mode code and, separately, a full-width initial count. Together they select one of five behaviours:

- an interrupt-on-terminal-count output;
- a periodic rate generator;
- a retriggerable one-shot;
- a software-started strobe;
- a GATE-started strobe.

The mode decides whether GATE acts as a level that enables counting or as a rising-edge trigger. It also decides when the count is reloaded and what OUT looks like.

Both host writes are single-cycle strobes with no back-pressure. The channel accepts every write in the cycle it is presented, so there is no valid/ready pair. GATE and OUT are plain level signals. An initial count of 0 stands for 65536.

Top module: `tmr_channel`

## Requirements
- R1: After reset OUT is high and the channel is disarmed. GATE activity produces no OUT change until a mode and a count are written.
- R2: A mode write drives OUT to the mode's idle level in the next cycle: low for code 0, high for every other code. Counting stops until a new count is written. A count write in the same cycle as a mode write is ignored.
- R3: Mode code 0 (terminal count), GATE held high. A count N written in the cycle ending at clock edge w makes OUT low from edge w, and OUT rises at edge w+1+N.
- R4: In the level-gated modes (codes 0, 2, 4), each clock edge with GATE low freezes the count. The OUT event is delayed by one cycle per such edge.
- R5: Mode code 1 (one-shot). OUT goes low on the first clock edge after GATE rises and stays low for exactly N cycles.
- R6: In mode code 1, a count written during a pulse leaves that pulse's length unchanged. The next GATE rising edge starts a pulse of the new length. Further rising edges repeat the pulse without a rewrite.
- R7: Mode code 2 (rate generator). OUT is low for one cycle at edge w+1+N and then once every N cycles. It is high in between.
- R8: Mode code 4 (software strobe). OUT is low for exactly one cycle at edge w+1+N, then stays high.
- R9: Mode code 5 (GATE strobe). The count loads on the first edge after GATE rises. OUT is low for one cycle N edges later. The strobe repeats on each later GATE rise.
- R10: Code 6 acts as code 2 and code 7 acts as code 3. Codes 3 and 7 leave the channel idle: OUT is high and count writes are ignored.
- R11: An initial count of 0 counts 65536 cycles: in mode code 0, OUT rises at edge w+65537.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | One-cycle mode write strobe |
| cfg_mode | input | 3 | Mode code, sampled with cfg_wr |
| cnt_wr | input | 1 | One-cycle count write strobe |
| cnt_val | input | 16 | Initial count, sampled with cnt_wr (0 means 65536) |
| gate | input | 1 | Enable level or trigger edge, depending on mode |
| out | output | 1 | Timer output |

## Verification
The checker watches several properties on every cycle:
- after each mode write, OUT takes the mode's idle level;
- codes 6 and 7 fold onto 2 and 3;
- in the level-gated modes the count never moves while GATE is low;
- a one-shot trigger pulls OUT low on the next edge;
- a strobe never lasts longer than one cycle.

Whole-pulse lengths need the bench's scenarios. These cover pulse lengths, rate-generator periods, suspension by GATE and the full 65536 count. They also cover a new count written during a one-shot, which takes effect only on the next trigger.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    M_TERM    = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_IDLE    = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } mode_e;

  // Codes 6 and 7 fold onto 2 and 3.
  function automatic mode_e decode_mode(input logic [2:0] code);
    if (code[2:1] == 2'b11) return mode_e'({1'b0, code[1:0]});
    return mode_e'(code);
  endfunction

  function automatic logic level_gated(input mode_e m);
    return (m == M_TERM) || (m == M_RATE) || (m == M_SWSTB);
  endfunction

  function automatic logic idle_level(input mode_e m);
    return (m != M_TERM);
  endfunction
endpackage

// File: rtl/tmr_gate_sense.sv
module tmr_gate_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic gate_rise
);
  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  assign gate_rise = gate & ~gate_q;
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         dec,
  input  logic         reload_at_tc,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         tc
);
  localparam logic [W-1:0] ONE = W'(1);

  // Terminal event: a decrement taken while the element holds one.
  assign tc = dec & (count == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '0;
    else if (load)             count <= load_val;
    else if (tc && reload_at_tc) count <= load_val;
    else if (dec)              count <= count - ONE;
  end
endmodule

// File: rtl/tmr_out_ctl.sv
module tmr_out_ctl
  import tmr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mode_wr,
  input  mode_e new_mode,
  input  mode_e mode_q,
  input  logic  accept,
  input  logic  load,
  input  logic  tc,
  output logic  out
);
  logic nxt;

  always_comb begin
    nxt = out;
    if (mode_wr) begin
      nxt = idle_level(new_mode);
    end else begin
      unique case (mode_q)
        M_TERM: begin
          if (accept)  nxt = 1'b0;
          else if (tc) nxt = 1'b1;
        end
        M_ONESHOT: begin
          if (load)    nxt = 1'b0;
          else if (tc) nxt = 1'b1;
        end
        M_IDLE:  nxt = 1'b1;
        default: nxt = ~tc;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out <= 1'b1;
    else        out <= nxt;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_mode,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             gate,
  output logic             out
);
  mode_e            mode_q;
  mode_e            new_mode;
  logic [CNT_W-1:0] cr_q;
  logic [CNT_W-1:0] ce_cur;
  logic             null_q, pend_q, active_q;
  logic             gate_rise, accept, load, dec, tc, lvl, restart;

  assign new_mode = decode_mode(cfg_mode);
  assign lvl      = level_gated(mode_q);
  assign accept   = cnt_wr & ~cfg_wr & (mode_q != M_IDLE);
  assign restart  = (mode_q == M_TERM) || (mode_q == M_SWSTB);
  assign load     = pend_q | (~lvl & gate_rise & ~null_q & (mode_q != M_IDLE));
  assign dec      = active_q & ~load & (~lvl | gate);

  tmr_gate_sense u_gate (
    .clk(clk), .rst_n(rst_n), .gate(gate), .gate_rise(gate_rise)
  );

  tmr_down_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .dec(dec),
    .reload_at_tc(mode_q == M_RATE), .load_val(cr_q),
    .count(ce_cur), .tc(tc)
  );

  tmr_out_ctl u_out (
    .clk(clk), .rst_n(rst_n), .mode_wr(cfg_wr), .new_mode(new_mode),
    .mode_q(mode_q), .accept(accept), .load(load), .tc(tc), .out(out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_IDLE;
      cr_q     <= '0;
      null_q   <= 1'b1;
      pend_q   <= 1'b0;
      active_q <= 1'b0;
    end else if (cfg_wr) begin
      mode_q   <= new_mode;
      null_q   <= 1'b1;
      pend_q   <= 1'b0;
      active_q <= 1'b0;
    end else begin
      if (accept) begin
        cr_q   <= cnt_val;
        null_q <= 1'b0;
      end
      if (accept && lvl && (mode_q != M_RATE || !active_q)) pend_q <= 1'b1;
      else if (pend_q)                                     pend_q <= 1'b0;
      if (load)                                  active_q <= 1'b1;
      else if (accept && restart)                active_q <= 1'b0;
      else if (tc && mode_q != M_RATE)           active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [2:0]       cfg_mode,
  input logic             gate,
  input logic             out,
  input logic [2:0]       mode_q,
  input logic [CNT_W-1:0] ce_cur,
  input logic             load,
  input logic             gate_rise,
  input logic             null_q
);
  p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (out == (decode_mode($past(cfg_mode)) != M_TERM)));

  p_gate_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (level_gated(mode_e'(mode_q)) && !gate && !load) |=> (ce_cur == $past(ce_cur)));

  p_oneshot_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ONESHOT && gate_rise && !null_q && !cfg_wr) |=> !out);

  p_strobe_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == M_SWSTB || mode_q == M_HWSTB) && !out && !cfg_wr) |=> out);

  p_alias_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_mode[2:1] == 2'b11) |=> (mode_q == {1'b0, $past(cfg_mode[1:0])}));
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
  .gate(gate), .out(out), .mode_q(mode_q), .ce_cur(ce_cur),
  .load(load), .gate_rise(gate_rise), .null_q(null_q)
);

// File: tb/tmr_channel_bench.sv
module tmr_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_mode = 3'd0;
  logic        cnt_wr = 1'b0;
  logic [15:0] cnt_val = 16'd0;
  logic        gate = 1'b0;
  logic        out;
  int nchk = 0, nerr = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_channel u_tmr_channel (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .cnt_wr(cnt_wr), .cnt_val(cnt_val), .gate(gate), .out(out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      nerr++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  // Expected run lengths, from the requirements.
  function automatic int exp_term_low(int n, int g); return n + 1 + g; endfunction
  function automatic int exp_first_high(int n); return n + 1; endfunction
  function automatic int exp_period_high(int n); return n - 1; endfunction

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_mode(int m);
    @(negedge clk); cfg_wr = 1'b1; cfg_mode = 3'(m);
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic wr_cnt(int v);
    @(negedge clk); cnt_wr = 1'b1; cnt_val = 16'(v);
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  task automatic run_low(output int n, input int lim);
    n = 0;
    while (out == 1'b0 && n < lim) begin n++; @(negedge clk); end
  endtask

  task automatic run_high(output int n, input int lim);
    n = 0;
    while (out == 1'b1 && n < lim) begin n++; @(negedge clk); end
  endtask

  task automatic term_gated(string req, int n, int g);
    int lows, r;
    gate = 1'b1;
    wr_cnt(n);
    lows = int'(!out);
    @(negedge clk); lows += int'(!out);
    @(negedge clk); lows += int'(!out);
    gate = 1'b0;
    for (int k = 0; k < g; k++) begin @(negedge clk); lows += int'(!out); end
    gate = 1'b1;
    @(negedge clk);
    run_low(r, 70000);
    check(req, lows + r, exp_term_low(n, g));
  endtask

  task automatic rate_check(string req, int n);
    int r;
    run_high(r, 500); check(req, r, exp_first_high(n));
    run_low(r, 500);  check(req, r, 1);
    run_high(r, 500); check(req, r, exp_period_high(n));
    run_low(r, 500);  check(req, r, 1);
  endtask

  initial begin
    int r, n, m;
    void'($urandom(32'h1234_5a5a));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, GATE edges ignored while disarmed
    check("R1", int'(out), 1);
    gate = 1'b1; @(negedge clk); gate = 1'b0; @(negedge clk); gate = 1'b1;
    run_high(r, 20); check("R1", r, 20);

    // R2: idle level after mode writes; no count means no counting
    wr_mode(0); check("R2", int'(out), 0);
    run_low(r, 40); check("R2", r, 40);
    wr_cnt(20); repeat (5) @(negedge clk);
    wr_mode(2); run_high(r, 60); check("R2", r, 60);
    @(negedge clk); cfg_wr = 1'b1; cfg_mode = 3'd4; cnt_wr = 1'b1; cnt_val = 16'd3;
    @(negedge clk); cfg_wr = 1'b0; cnt_wr = 1'b0;
    run_high(r, 40); check("R2", r, 40);

    // R3: terminal count
    wr_mode(0); gate = 1'b1;
    wr_cnt(7); run_low(r, 500); check("R3", r, exp_term_low(7, 0));
    // R4: suspension by GATE low
    term_gated("R4", 10, 5);

    // R5, R6: one-shot
    wr_mode(1); check("R5", int'(out), 1);
    gate = 1'b0; wr_cnt(6);
    @(negedge clk); gate = 1'b1; @(negedge clk);
    run_low(r, 500); check("R5", r, 6);
    gate = 1'b0; @(negedge clk); gate = 1'b1; @(negedge clk);
    wr_cnt(11);
    run_low(r, 500); check("R6", r, 6 - 2);
    gate = 1'b0; @(negedge clk); gate = 1'b1; @(negedge clk);
    run_low(r, 500); check("R6", r, 11);
    gate = 1'b0; @(negedge clk); gate = 1'b1; @(negedge clk);
    run_low(r, 500); check("R6", r, 11);

    // R7: rate generator
    gate = 1'b1; wr_mode(2); wr_cnt(5);
    rate_check("R7", 5);

    // R8: software strobe, fires once
    wr_mode(4); wr_cnt(8);
    run_high(r, 500); check("R8", r, exp_first_high(8));
    run_low(r, 500);  check("R8", r, 1);
    run_high(r, 24);  check("R8", r, 24);

    // R9: GATE strobe, repeats on each rise
    gate = 1'b0; wr_mode(5); wr_cnt(4);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); gate = 1'b1; @(negedge clk);
      run_high(r, 500); check("R9", r, 4);
      run_low(r, 500);  check("R9", r, 1);
      gate = 1'b0;
    end

    // R10: aliases and idle codes
    gate = 1'b1; wr_mode(6); wr_cnt(3);
    rate_check("R10", 3);
    wr_mode(7); check("R10", int'(out), 1);
    wr_cnt(2); gate = 1'b0; @(negedge clk); gate = 1'b1;
    run_high(r, 30); check("R10", r, 30);

    // Randomised runs across level-gated modes
    for (int i = 0; i < 12; i++) begin
      n = int'($urandom_range(40, 3));
      m = int'($urandom_range(2, 0));
      if (m == 0) begin
        wr_mode(0);
        term_gated("R4", n, int'($urandom_range(10, 0)));
      end else if (m == 1) begin
        gate = 1'b1; wr_mode(2); wr_cnt(n);
        rate_check("R7", n);
      end else begin
        gate = 1'b1; wr_mode(4); wr_cnt(n);
        run_high(r, 500); check("R8", r, exp_first_high(n));
        run_low(r, 500);  check("R8", r, 1);
      end
    end

    // R11: zero count means 65536
    gate = 1'b1; wr_mode(0); wr_cnt(0);
    run_low(r, 70000); check("R11", r, 65537);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule